// File: doc/BRIEF.md
# Vsync-Latched Window Shadow Register Bank

This block keeps the display configuration of each overlay window as a pair of copies. Register writes from the control side always update a pending copy. The active copy drives the pixel pipeline, and it is refreshed from the pending copy only when vertical sync begins. Because of this, a window that is being reprogrammed never shows a half-updated set of frame start, frame end, placement, area and enable values in the middle of a frame.

Software can hold back the refresh for one window with that window's protect bit. It sets the bit, writes several registers, then clears the bit, and the whole group of values lands together at the next vsync. A global protect input holds back every window in the same way. Each window has a window-enable bit and a data-path (channel) enable bit. The window is shown only when both active bits are set. Clearing either bit takes effect only at the next vsync, so a window never goes dark in the middle of a frame.

The write port is a plain single-cycle strobe. It accepts a write in every cycle and never applies back-pressure. The read port is combinational and returns the pending copy.

Top module: `win_shadow_bank`

## Requirements
- R1: After reset, every pending and active field of every window reads zero, and `act_on_o` is all zero.
- R2: A write with `wr_en_i` high updates the pending field picked by `wr_win_i`/`wr_sel_i`. Field codes: 0 frame start, 1 frame end, 2 placement, 3 area, 4 control. The read port shows the new value after that clock edge. The active outputs do not change.
- R3: In the clock cycle where `vsync_i` is first seen high after being low, every unprotected window copies all pending fields to active. The new values are visible after that edge. While `vsync_i` stays high, no further copy happens.
- R4: A window whose `prot_win_i` bit is high at the vsync rising edge keeps its active values. Unprotected windows still copy.
- R5: Clearing a protect bit does not copy anything by itself. The held pending values reach the active outputs at the next vsync rising edge.
- R6: With `prot_all_i` high at the vsync rising edge, no window copies.
- R7: A write in the same cycle as the vsync rising edge lands only in the pending copy. The active copy receives the pending value from before that write.
- R8: Clearing a control enable bit leaves `act_on_o` for that window unchanged until the next unprotected vsync rising edge.
- R9: Control field bit 0 is the window enable and bit 1 is the channel enable. `act_on_o[w]` is high only when both active bits of window w are set.
- R10: Writes with field code 5 to 7, or with a window index of `NUM_WIN` or above, change no pending or active state. A read of such a window returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_win_i | input | WIN_IDX_W (3) | Window index of the write |
| wr_sel_i | input | 3 | Field code of the write |
| wr_data_i | input | DATA_W (32) | Write data (control uses bits 1:0) |
| rd_win_i | input | WIN_IDX_W (3) | Window index of the read |
| rd_sel_i | input | 3 | Field code of the read |
| rd_data_o | output | DATA_W (32) | Pending value of the addressed field |
| vsync_i | input | 1 | Vertical sync level, synchronous to clk |
| prot_win_i | input | NUM_WIN (5) | Per-window copy hold |
| prot_all_i | input | 1 | Copy hold for all windows |
| act_start_o | output | NUM_WIN*DATA_W (160) | Active frame start, window w at bits w*DATA_W |
| act_end_o | output | NUM_WIN*DATA_W (160) | Active frame end |
| act_pos_o | output | NUM_WIN*DATA_W (160) | Active placement |
| act_size_o | output | NUM_WIN*DATA_W (160) | Active area |
| act_ctrl_o | output | NUM_WIN*2 (10) | Active control bits per window |
| act_on_o | output | NUM_WIN (5) | Window shown |

## Verification
The assertions assume that `vsync_i`, the protect bits and the write port are synchronous to `clk` and settled before each rising edge. They also assume the only start of a copy is a low-to-high step of `vsync_i` seen at an edge. The stimulus changes every input just after a rising edge and holds `vsync_i` high for several cycles, so the level cases and the edge cases are both covered. Protect bits are set before the edge they are meant to hold and are cleared between vsync pulses. This keeps each hold-and-release sequence clear of any ambiguity.

// File: rtl/win_shadow_pkg.sv
package win_shadow_pkg;
  localparam int SEL_W  = 3;
  localparam int CTRL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    F_START = 3'd0,
    F_END   = 3'd1,
    F_POS   = 3'd2,
    F_SIZE  = 3'd3,
    F_CTRL  = 3'd4
  } fld_e;
endpackage

// File: rtl/win_shadow_vs_edge.sv
module win_shadow_vs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync_i,
  output logic rise_o
);
  logic vs_q;
  always_ff @(posedge clk) begin
    if (!rst_n) vs_q <= 1'b0;
    else        vs_q <= vsync_i;
  end
  assign rise_o = vsync_i & ~vs_q;
endmodule

// File: rtl/win_shadow_slot.sv
module win_shadow_slot
  import win_shadow_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] pend_start_o,
  output logic [DATA_W-1:0] pend_end_o,
  output logic [DATA_W-1:0] pend_pos_o,
  output logic [DATA_W-1:0] pend_size_o,
  output logic [CTRL_W-1:0] pend_ctrl_o,
  output logic [DATA_W-1:0] act_start_o,
  output logic [DATA_W-1:0] act_end_o,
  output logic [DATA_W-1:0] act_pos_o,
  output logic [DATA_W-1:0] act_size_o,
  output logic [CTRL_W-1:0] act_ctrl_o
);
  // pending side: software writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_start_o <= '0;
      pend_end_o   <= '0;
      pend_pos_o   <= '0;
      pend_size_o  <= '0;
      pend_ctrl_o  <= '0;
    end else if (wr_hit_i) begin
      case (wr_sel_i)
        F_START: pend_start_o <= wr_data_i;
        F_END:   pend_end_o   <= wr_data_i;
        F_POS:   pend_pos_o   <= wr_data_i;
        F_SIZE:  pend_size_o  <= wr_data_i;
        F_CTRL:  pend_ctrl_o  <= wr_data_i[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  // active side: loaded from pre-write pending values
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_start_o <= '0;
      act_end_o   <= '0;
      act_pos_o   <= '0;
      act_size_o  <= '0;
      act_ctrl_o  <= '0;
    end else if (load_i) begin
      act_start_o <= pend_start_o;
      act_end_o   <= pend_end_o;
      act_pos_o   <= pend_pos_o;
      act_size_o  <= pend_size_o;
      act_ctrl_o  <= pend_ctrl_o;
    end
  end
endmodule

// File: rtl/win_shadow_bank.sv
module win_shadow_bank
  import win_shadow_pkg::*;
#(
  parameter int NUM_WIN   = 5,
  parameter int DATA_W    = 32,
  parameter int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [WIN_IDX_W-1:0]        wr_win_i,
  input  logic [SEL_W-1:0]            wr_sel_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic [WIN_IDX_W-1:0]        rd_win_i,
  input  logic [SEL_W-1:0]            rd_sel_i,
  output logic [DATA_W-1:0]           rd_data_o,
  input  logic                        vsync_i,
  input  logic [NUM_WIN-1:0]          prot_win_i,
  input  logic                        prot_all_i,
  output logic [NUM_WIN*DATA_W-1:0]   act_start_o,
  output logic [NUM_WIN*DATA_W-1:0]   act_end_o,
  output logic [NUM_WIN*DATA_W-1:0]   act_pos_o,
  output logic [NUM_WIN*DATA_W-1:0]   act_size_o,
  output logic [NUM_WIN*CTRL_W-1:0]   act_ctrl_o,
  output logic [NUM_WIN-1:0]          act_on_o
);
  logic vs_rise;
  logic [DATA_W-1:0] p_start [NUM_WIN];
  logic [DATA_W-1:0] p_end   [NUM_WIN];
  logic [DATA_W-1:0] p_pos   [NUM_WIN];
  logic [DATA_W-1:0] p_size  [NUM_WIN];
  logic [CTRL_W-1:0] p_ctrl  [NUM_WIN];

  win_shadow_vs_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .vsync_i (vsync_i),
    .rise_o  (vs_rise)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic hit, load;
    assign hit  = wr_en_i && (wr_win_i == WIN_IDX_W'(w));
    assign load = vs_rise && !prot_all_i && !prot_win_i[w];

    win_shadow_slot #(.DATA_W(DATA_W)) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_hit_i     (hit),
      .wr_sel_i     (wr_sel_i),
      .wr_data_i    (wr_data_i),
      .load_i       (load),
      .pend_start_o (p_start[w]),
      .pend_end_o   (p_end[w]),
      .pend_pos_o   (p_pos[w]),
      .pend_size_o  (p_size[w]),
      .pend_ctrl_o  (p_ctrl[w]),
      .act_start_o  (act_start_o[w*DATA_W +: DATA_W]),
      .act_end_o    (act_end_o[w*DATA_W +: DATA_W]),
      .act_pos_o    (act_pos_o[w*DATA_W +: DATA_W]),
      .act_size_o   (act_size_o[w*DATA_W +: DATA_W]),
      .act_ctrl_o   (act_ctrl_o[w*CTRL_W +: CTRL_W])
    );

    // shown only when window and channel enable are both active
    assign act_on_o[w] = &act_ctrl_o[w*CTRL_W +: CTRL_W];
  end

  always_comb begin
    rd_data_o = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (rd_win_i == WIN_IDX_W'(w)) begin
        case (rd_sel_i)
          F_START: rd_data_o = p_start[w];
          F_END:   rd_data_o = p_end[w];
          F_POS:   rd_data_o = p_pos[w];
          F_SIZE:  rd_data_o = p_size[w];
          F_CTRL:  rd_data_o = DATA_W'(p_ctrl[w]);
          default: rd_data_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/win_shadow_bank_chk.sv
module win_shadow_bank_chk #(
  parameter int NUM_WIN = 5,
  parameter int DATA_W  = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      vsync_i,
  input logic [NUM_WIN-1:0]        prot_win_i,
  input logic                      prot_all_i,
  input logic [NUM_WIN*DATA_W-1:0] act_start_o,
  input logic [NUM_WIN*DATA_W-1:0] act_end_o,
  input logic [NUM_WIN*DATA_W-1:0] act_pos_o,
  input logic [NUM_WIN*DATA_W-1:0] act_size_o,
  input logic [NUM_WIN*2-1:0]      act_ctrl_o,
  input logic [NUM_WIN-1:0]        act_on_o
);
  logic seen_vs;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_vs <= 1'b0;
    else        seen_vs <= vsync_i;
  end
  logic frame_start;
  assign frame_start = vsync_i && !seen_vs;

  // R3
  hold_between_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(act_start_o) && $stable(act_end_o) && $stable(act_pos_o)
                      && $stable(act_size_o) && $stable(act_ctrl_o)));

  // R6
  global_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && prot_all_i) |=> ($stable(act_start_o) && $stable(act_end_o)
                      && $stable(act_pos_o) && $stable(act_size_o) && $stable(act_ctrl_o)));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_c
    // R4
    window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && prot_win_i[w]) |=>
        ($stable(act_start_o[w*DATA_W +: DATA_W]) && $stable(act_end_o[w*DATA_W +: DATA_W])
         && $stable(act_pos_o[w*DATA_W +: DATA_W]) && $stable(act_size_o[w*DATA_W +: DATA_W])
         && $stable(act_ctrl_o[w*2 +: 2])));

    // R8
    dark_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act_on_o[w]) |-> $past(frame_start));
  end
endmodule

bind win_shadow_bank win_shadow_bank_chk #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/win_shadow_bank_tb_top.sv
module win_shadow_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 5;
  localparam int DW = 32;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en_i = 1'b0;
  logic [IW-1:0] wr_win_i = '0;
  logic [2:0] wr_sel_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [IW-1:0] rd_win_i = '0;
  logic [2:0] rd_sel_i = '0;
  logic [DW-1:0] rd_data_o;
  logic vsync_i = 1'b0;
  logic [NW-1:0] prot_win_i = '0;
  logic prot_all_i = 1'b0;
  logic [NW*DW-1:0] act_start_o, act_end_o, act_pos_o, act_size_o;
  logic [NW*2-1:0] act_ctrl_o;
  logic [NW-1:0] act_on_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_shadow_bank #(.NUM_WIN(NW), .DATA_W(DW)) dut_i (.*);

  typedef struct {
    string tag;
    int w;
    int f;
    logic [DW-1:0] exp;
  } item_t;
  item_t sb_q[$];

  logic [DW-1:0] pend [NW][5];
  logic [DW-1:0] act  [NW][5];
  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [DW-1:0] dut_field(int w, int f);
    case (f)
      0: return act_start_o[w*DW +: DW];
      1: return act_end_o[w*DW +: DW];
      2: return act_pos_o[w*DW +: DW];
      3: return act_size_o[w*DW +: DW];
      4: return DW'(act_ctrl_o[w*2 +: 2]);
      default: return DW'(act_on_o[w]);
    endcase
  endfunction

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [DW-1:0] got;
      it = sb_q.pop_front();
      got = dut_field(it.w, it.f);
      n_chk++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s win%0d fld%0d act=%h exp=%h", it.tag, it.w, it.f, got, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_all(string tag);
    for (int w = 0; w < NW; w++) begin
      for (int f = 0; f < 5; f++) sb_q.push_back('{tag, w, f, act[w][f]});
      sb_q.push_back('{tag, w, 5, DW'(act[w][4][1:0] == 2'b11)});
    end
    @(negedge clk);
  endtask

  task automatic check_rd(string tag, int w, int s, logic [DW-1:0] exp);
    rd_win_i = IW'(w);
    rd_sel_i = 3'(s);
    #1;
    n_chk++;
    if (rd_data_o !== exp) begin
      n_bad++;
      $display("FAIL %s read win%0d sel%0d act=%h exp=%h", tag, w, s, rd_data_o, exp);
    end
  endtask

  function automatic void model_write(int w, int s, logic [DW-1:0] d);
    if (w < NW && s < 5) pend[w][s] = (s == 4) ? (d & 32'h3) : d;
  endfunction

  function automatic void model_copy();
    for (int w = 0; w < NW; w++)
      if (!prot_all_i && !prot_win_i[w])
        for (int f = 0; f < 5; f++) act[w][f] = pend[w][f];
  endfunction

  task automatic do_write(int w, int s, logic [DW-1:0] d);
    wr_en_i = 1'b1; wr_win_i = IW'(w); wr_sel_i = 3'(s); wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
    model_write(w, s, d);
  endtask

  task automatic do_vsync();
    vsync_i = 1'b1;
    tick();
    model_copy();
    tick(); tick();
    vsync_i = 1'b0;
    tick();
  endtask

  task automatic fill_win(int w, int seed);
    for (int s = 0; s < 5; s++) do_write(w, s, 32'h1000_0000 * seed + 32'h11 * (s + 1));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < NW; w++)
      for (int f = 0; f < 5; f++) begin pend[w][f] = '0; act[w][f] = '0; end
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    expect_all("R1");
    for (int w = 0; w < NW; w++) check_rd("R1", w, 0, '0);

    // R2 writes reach pending only
    fill_win(0, 1);
    fill_win(3, 3);
    check_rd("R2", 0, 2, pend[0][2]);
    check_rd("R2", 3, 4, pend[3][4]);
    expect_all("R2");

    // R3 copy at rising edge, none while level stays high
    vsync_i = 1'b1;
    tick();
    model_copy();
    expect_all("R3");
    do_write(0, 0, 32'hDEAD_0001);
    tick();
    expect_all("R3");
    vsync_i = 1'b0;
    tick();

    // R4 per-window hold, R5 release only at later vsync
    fill_win(1, 5);
    fill_win(2, 6);
    prot_win_i = 5'b00010;
    do_vsync();
    expect_all("R4");
    prot_win_i = '0;
    tick(); tick();
    expect_all("R5");
    do_vsync();
    expect_all("R5");

    // R6 global hold
    fill_win(4, 7);
    prot_all_i = 1'b1;
    do_vsync();
    expect_all("R6");
    prot_all_i = 1'b0;
    do_vsync();
    expect_all("R6");

    // R7 write in the edge cycle
    do_write(3, 1, 32'hAAAA_0000);
    wr_en_i = 1'b1; wr_win_i = 3; wr_sel_i = 1; wr_data_i = 32'hBBBB_0000;
    vsync_i = 1'b1;
    tick();
    wr_en_i = 1'b0;
    model_copy();
    model_write(3, 1, 32'hBBBB_0000);
    expect_all("R7");
    check_rd("R7", 3, 1, 32'hBBBB_0000);
    vsync_i = 1'b0;
    tick();
    do_vsync();
    expect_all("R7");

    // R9 both enables needed, R8 disable waits for vsync
    do_write(2, 4, 32'h3);
    do_vsync();
    expect_all("R9");
    do_write(2, 4, 32'h1);
    tick(); tick();
    expect_all("R8");
    do_vsync();
    expect_all("R8");
    do_write(2, 4, 32'h2);
    do_vsync();
    expect_all("R9");

    // R10 invalid field code and window index ignored
    do_write(1, 6, 32'hFFFF_FFFF);
    do_write(1, 5, 32'hFFFF_FFFF);
    do_write(6, 0, 32'hFFFF_FFFF);
    do_write(7, 4, 32'hFFFF_FFFF);
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < 5; s++) check_rd("R10", w, s, pend[w][s]);
    check_rd("R10", 6, 0, '0);
    do_vsync();
    expect_all("R10");

    tick();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule